// File: doc/BRIEF.md
# USB Device State Tracker

This block follows the device-level state of a USB peripheral controller. The protocol layer hands it single-cycle event pulses: bus reset seen, SET_ADDRESS finished, SET_CONFIGURATION finished together with its configuration value, suspend seen, resume seen, and setup token fully received. From these the block keeps a 3-bit state code and three sticky status flags. The flags are a device-state-change flag that is gated by one enable per cause, a resume flag, and a setup-received flag.

The suspended states keep the state that was active before the suspend in their two low bits, so a resume restores that state directly. A cause enable only decides whether the change flag is raised. The state moves whether the enable is set or not. Software clears a flag by writing 0 to it through a plain write port. While the setup-received flag is set, the block drops writes to the endpoint-0 handshake (PID) field and the control-complete field, so that a new setup stage is not disturbed. All outputs come from registers and change one clock after the event that causes them. There is no data stream, so every pin is a plain control or status signal and none has a valid/ready handshake.

Top module: `usb_dev_state_tracker`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `dev_state` is 000 and `chg_flag`, `resume_flag`, `setup_flag`, `ep0_pid` and `ep0_ccpl` are all 0.
- R2: The state codes are Powered=000, Default=001, Address=010 and Configured=011. Suspended adds 100 to the code of the state that was left. A bus reset moves the device to Default (001) from any state, suspended states included, and it overrides every other event in the same cycle.
- R3: SET_ADDRESS moves Default to Address. In every other state it has no effect.
- R4: SET_CONFIGURATION with a nonzero value moves Address to Configured. With a zero value it moves Configured to Address. Every other combination of state and value leaves the state unchanged.
- R5: A suspend in a non-suspended state sets bit 2 of the state code and keeps bits 1:0. In that same cycle it wins over SET_ADDRESS and SET_CONFIGURATION. A suspend in a suspended state has no effect.
- R6: A resume in a suspended state clears bit 2 of the state code and sets `resume_flag`. A resume in a non-suspended state has no effect. While the device is suspended, SET_ADDRESS, SET_CONFIGURATION and suspend have no effect.
- R7: `chg_flag` is set when one of these transitions is taken and its own enable is 1: bus reset (`en_reset`), address (`en_addr`), either configuration move (`en_cfg`), or suspend entry (`en_susp`). A bus reset counts as taken even when the device is already in Default. Resume never sets `chg_flag`. The transition happens whatever the enable is.
- R8: `chg_flag` (select 0) and `resume_flag` (select 1) are sticky. A write with `reg_sel` set to that select and `reg_wdata`=0 clears the flag. A write of 1, or a write to select 3, has no effect. If a set and a clear fall in the same cycle, the flag stays set.
- R9: `setup_flag` (select 2) is set by `setup_evt` and cleared by a write of 0 to select 2. A set wins over a clear in the same cycle.
- R10: An endpoint-0 write (`ep0_wr`) loads `ep0_pid` and `ep0_ccpl` on the next edge when `setup_flag` is 0. It is ignored when `setup_flag` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reset_evt | input | 1 | Bus reset detected (pulse) |
| set_addr_evt | input | 1 | SET_ADDRESS completed (pulse) |
| set_cfg_evt | input | 1 | SET_CONFIGURATION completed (pulse) |
| cfg_value | input | CFG_W | Configuration value that goes with `set_cfg_evt` |
| suspend_evt | input | 1 | Suspend detected (pulse) |
| resume_evt | input | 1 | Resume detected (pulse) |
| setup_evt | input | 1 | Setup token fully received (pulse) |
| en_reset | input | 1 | Change-flag enable for bus reset |
| en_addr | input | 1 | Change-flag enable for the address move |
| en_cfg | input | 1 | Change-flag enable for configuration moves |
| en_susp | input | 1 | Change-flag enable for suspend entry |
| reg_wr | input | 1 | Flag write strobe |
| reg_sel | input | 2 | Flag select: 0 change, 1 resume, 2 setup, 3 none |
| reg_wdata | input | 1 | Written bit; only 0 has an effect |
| ep0_wr | input | 1 | Endpoint-0 control field write strobe |
| ep0_pid_wdata | input | PID_W | New handshake field value |
| ep0_ccpl_wdata | input | 1 | New control-complete value |
| dev_state | output | 3 | Device state code |
| chg_flag | output | 1 | Sticky device-state-change flag |
| resume_flag | output | 1 | Sticky resume flag |
| setup_flag | output | 1 | Sticky setup-received flag |
| ep0_pid | output | PID_W | Endpoint-0 handshake field |
| ep0_ccpl | output | 1 | Endpoint-0 control-complete field |

## Verification
The assertions assume that every event input is sampled only at the rising clock edge and is free to coincide with any other event. They also assume that `cfg_value` is only meaningful in a cycle where `set_cfg_evt` is high, and that no input carries X once reset has been released. The stimulus drives all inputs on the falling edge. It starts with directed sequences for each transition and corner case, then runs a long random phase. That phase mixes simultaneous events, toggling enables, writes to every select value including the unused one, and endpoint-0 writes both while the setup flag is held and while it is clear.

// File: rtl/usb_dst_pkg.sv
package usb_dst_pkg;
  localparam int STATE_W = 3;
  localparam int SEL_W   = 2;
  localparam int NFLAG   = 3;

  localparam logic [STATE_W-1:0] ST_POWERED    = 3'b000;
  localparam logic [STATE_W-1:0] ST_DEFAULT    = 3'b001;
  localparam logic [STATE_W-1:0] ST_ADDRESS    = 3'b010;
  localparam logic [STATE_W-1:0] ST_CONFIGURED = 3'b011;

  // flag index doubles as the write select code
  localparam int FLG_CHG   = 0;
  localparam int FLG_RESM  = 1;
  localparam int FLG_SETUP = 2;
endpackage

// File: rtl/dst_state_fsm.sv
module dst_state_fsm
  import usb_dst_pkg::*;
#(
  parameter int CFG_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ev_bus_reset_i,
  input  logic               ev_set_addr_i,
  input  logic               ev_set_cfg_i,
  input  logic [CFG_W-1:0]   cfg_value_i,
  input  logic               ev_suspend_i,
  input  logic               ev_resume_i,
  input  logic               en_reset_i,
  input  logic               en_addr_i,
  input  logic               en_cfg_i,
  input  logic               en_susp_i,
  output logic [STATE_W-1:0] state_o,
  output logic               chg_set_o,
  output logic               resm_set_o
);
  logic [STATE_W-1:0] state_q, state_d;
  logic               cfg_nonzero;
  logic               suspended;

  assign cfg_nonzero = |cfg_value_i;
  assign suspended   = state_q[STATE_W-1];

  always_comb begin
    state_d    = state_q;
    chg_set_o  = 1'b0;
    resm_set_o = 1'b0;
    if (ev_bus_reset_i) begin
      state_d   = ST_DEFAULT;
      chg_set_o = en_reset_i;
    end else if (suspended) begin
      if (ev_resume_i) begin
        state_d    = {1'b0, state_q[STATE_W-2:0]};
        resm_set_o = 1'b1;
      end
    end else if (ev_suspend_i) begin
      state_d   = {1'b1, state_q[STATE_W-2:0]};
      chg_set_o = en_susp_i;
    end else if (ev_set_addr_i && state_q == ST_DEFAULT) begin
      state_d   = ST_ADDRESS;
      chg_set_o = en_addr_i;
    end else if (ev_set_cfg_i && cfg_nonzero && state_q == ST_ADDRESS) begin
      state_d   = ST_CONFIGURED;
      chg_set_o = en_cfg_i;
    end else if (ev_set_cfg_i && !cfg_nonzero && state_q == ST_CONFIGURED) begin
      state_d   = ST_ADDRESS;
      chg_set_o = en_cfg_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_POWERED;
    else        state_q <= state_d;
  end

  assign state_o = state_q;

  assert_bus_reset_default_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bus_reset_i |=> state_q == ST_DEFAULT);

  assert_suspend_keeps_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_bus_reset_i && !state_q[2] && ev_suspend_i)
      |=> state_q == {1'b1, $past(state_q[1:0])});

  assert_resume_restores_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_bus_reset_i && state_q[2] && ev_resume_i)
      |=> state_q == {1'b0, $past(state_q[1:0])});

  assert_suspended_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_bus_reset_i && state_q[2] && !ev_resume_i) |=> $stable(state_q));

  assert_chg_has_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    chg_set_o |-> ((ev_bus_reset_i && en_reset_i) || (ev_suspend_i && en_susp_i) ||
                   (ev_set_addr_i && en_addr_i) || (ev_set_cfg_i && en_cfg_i)));
endmodule

// File: rtl/dst_sticky_flag.sv
module dst_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);

  assert_clear_works_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o);

  assert_rise_needs_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q_o) |-> $past(set_i));
endmodule

// File: rtl/dst_ep0_ctrl.sv
module dst_ep0_ctrl #(
  parameter int PID_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lock_i,
  input  logic             wr_i,
  input  logic [PID_W-1:0] pid_wdata_i,
  input  logic             ccpl_wdata_i,
  output logic [PID_W-1:0] pid_o,
  output logic             ccpl_o
);
  logic accept;
  assign accept = wr_i && !lock_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pid_o  <= '0;
      ccpl_o <= 1'b0;
    end else if (accept) begin
      pid_o  <= pid_wdata_i;
      ccpl_o <= ccpl_wdata_i;
    end
  end

  assert_locked_ignores_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lock_i |=> ($stable(pid_o) && $stable(ccpl_o)));

  assert_unlocked_loads_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !lock_i) |=> (pid_o == $past(pid_wdata_i) && ccpl_o == $past(ccpl_wdata_i)));
endmodule

// File: rtl/usb_dev_state_tracker.sv
module usb_dev_state_tracker
  import usb_dst_pkg::*;
#(
  parameter int CFG_W = 8,
  parameter int PID_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_reset_evt,
  input  logic             set_addr_evt,
  input  logic             set_cfg_evt,
  input  logic [CFG_W-1:0] cfg_value,
  input  logic             suspend_evt,
  input  logic             resume_evt,
  input  logic             setup_evt,
  input  logic             en_reset,
  input  logic             en_addr,
  input  logic             en_cfg,
  input  logic             en_susp,
  input  logic             reg_wr,
  input  logic [1:0]       reg_sel,
  input  logic             reg_wdata,
  input  logic             ep0_wr,
  input  logic [PID_W-1:0] ep0_pid_wdata,
  input  logic             ep0_ccpl_wdata,
  output logic [2:0]       dev_state,
  output logic             chg_flag,
  output logic             resume_flag,
  output logic             setup_flag,
  output logic [PID_W-1:0] ep0_pid,
  output logic             ep0_ccpl
);
  logic             chg_set, resm_set;
  logic [NFLAG-1:0] flag_set, flag_clr, flag_q;

  dst_state_fsm #(.CFG_W(CFG_W)) u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .ev_bus_reset_i (bus_reset_evt),
    .ev_set_addr_i  (set_addr_evt),
    .ev_set_cfg_i   (set_cfg_evt),
    .cfg_value_i    (cfg_value),
    .ev_suspend_i   (suspend_evt),
    .ev_resume_i    (resume_evt),
    .en_reset_i     (en_reset),
    .en_addr_i      (en_addr),
    .en_cfg_i       (en_cfg),
    .en_susp_i      (en_susp),
    .state_o        (dev_state),
    .chg_set_o      (chg_set),
    .resm_set_o     (resm_set)
  );

  always_comb begin
    flag_set            = '0;
    flag_set[FLG_CHG]   = chg_set;
    flag_set[FLG_RESM]  = resm_set;
    flag_set[FLG_SETUP] = setup_evt;
  end

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    localparam logic [SEL_W-1:0] SEL_CODE = SEL_W'(g);
    assign flag_clr[g] = reg_wr && (reg_sel == SEL_CODE) && !reg_wdata;
    dst_sticky_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (flag_set[g]),
      .clr_i (flag_clr[g]),
      .q_o   (flag_q[g])
    );
  end

  assign chg_flag    = flag_q[FLG_CHG];
  assign resume_flag = flag_q[FLG_RESM];
  assign setup_flag  = flag_q[FLG_SETUP];

  dst_ep0_ctrl #(.PID_W(PID_W)) u_ep0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .lock_i       (setup_flag),
    .wr_i         (ep0_wr),
    .pid_wdata_i  (ep0_pid_wdata),
    .ccpl_wdata_i (ep0_ccpl_wdata),
    .pid_o        (ep0_pid),
    .ccpl_o       (ep0_ccpl)
  );

  assert_resume_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_reset_evt && dev_state[2] && resume_evt) |=> resume_flag);

  assert_setup_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    setup_evt |=> setup_flag);

  assert_unused_sel_inert_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 2'd3 && chg_flag && resume_flag && setup_flag)
      |=> (chg_flag && resume_flag && setup_flag));
endmodule

// File: tb/test_usb_dev_state_tracker.sv
module test_usb_dev_state_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int CFG_W = 8;
  localparam int PID_W = 2;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_reset_evt = 0, set_addr_evt = 0, set_cfg_evt = 0, suspend_evt = 0;
  logic resume_evt = 0, setup_evt = 0;
  logic [CFG_W-1:0] cfg_value = '0;
  logic en_reset = 0, en_addr = 0, en_cfg = 0, en_susp = 0;
  logic reg_wr = 0, reg_wdata = 0;
  logic [1:0] reg_sel = '0;
  logic ep0_wr = 0, ep0_ccpl_wdata = 0;
  logic [PID_W-1:0] ep0_pid_wdata = '0;
  logic [2:0] dev_state;
  logic chg_flag, resume_flag, setup_flag, ep0_ccpl;
  logic [PID_W-1:0] ep0_pid;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_dev_state_tracker #(.CFG_W(CFG_W), .PID_W(PID_W)) i_usb_dev_state_tracker (
    .clk(clk), .rst_n(rst_n),
    .bus_reset_evt(bus_reset_evt), .set_addr_evt(set_addr_evt),
    .set_cfg_evt(set_cfg_evt), .cfg_value(cfg_value),
    .suspend_evt(suspend_evt), .resume_evt(resume_evt), .setup_evt(setup_evt),
    .en_reset(en_reset), .en_addr(en_addr), .en_cfg(en_cfg), .en_susp(en_susp),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .ep0_wr(ep0_wr), .ep0_pid_wdata(ep0_pid_wdata), .ep0_ccpl_wdata(ep0_ccpl_wdata),
    .dev_state(dev_state), .chg_flag(chg_flag), .resume_flag(resume_flag),
    .setup_flag(setup_flag), .ep0_pid(ep0_pid), .ep0_ccpl(ep0_ccpl)
  );

  // behavioural reference model
  int m_state = 0;
  bit m_chg = 0, m_resm = 0, m_setup = 0, m_ccpl = 0;
  int m_pid = 0;

  always @(posedge clk) begin
    int nxt;
    bit chg, res;
    if (!rst_n) begin
      m_state = 0; m_chg = 0; m_resm = 0; m_setup = 0; m_pid = 0; m_ccpl = 0;
    end else begin
      nxt = m_state; chg = 0; res = 0;
      if (bus_reset_evt) begin nxt = 1; chg = en_reset; end
      else if (m_state >= 4) begin
        if (resume_evt) begin nxt = m_state - 4; res = 1; end
      end
      else if (suspend_evt) begin nxt = m_state + 4; chg = en_susp; end
      else if (set_addr_evt && m_state == 1) begin nxt = 2; chg = en_addr; end
      else if (set_cfg_evt && m_state == 2 && cfg_value != 0) begin nxt = 3; chg = en_cfg; end
      else if (set_cfg_evt && m_state == 3 && cfg_value == 0) begin nxt = 2; chg = en_cfg; end
      if (ep0_wr && !m_setup) begin m_pid = int'(ep0_pid_wdata); m_ccpl = ep0_ccpl_wdata; end
      m_chg   = chg       || (m_chg   && !(reg_wr && reg_sel == 0 && !reg_wdata));
      m_resm  = res       || (m_resm  && !(reg_wr && reg_sel == 1 && !reg_wdata));
      m_setup = setup_evt || (m_setup && !(reg_wr && reg_sel == 2 && !reg_wdata));
      m_state = nxt;
    end
  end

  int n_checks = 0, n_fail = 0, cycles = 0;
  bit checking = 0, done = 0;
  string phase = "R1";

  task automatic chk(string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", phase, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (checking && !done) begin
      chk("dev_state",   int'(dev_state),   m_state);
      chk("chg_flag",    int'(chg_flag),    int'(m_chg));
      chk("resume_flag", int'(resume_flag), int'(m_resm));
      chk("setup_flag",  int'(setup_flag),  int'(m_setup));
      chk("ep0_pid",     int'(ep0_pid),     m_pid);
      chk("ep0_ccpl",    int'(ep0_ccpl),    int'(m_ccpl));
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected at most %0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  task automatic idle();
    bus_reset_evt = 0; set_addr_evt = 0; set_cfg_evt = 0; suspend_evt = 0;
    resume_evt = 0; setup_evt = 0; reg_wr = 0; ep0_wr = 0;
  endtask

  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic clr_flag(int sel);
    reg_wr = 1; reg_sel = 2'(sel); reg_wdata = 0; step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checking = 1;                       // R1: checks during reset
    @(negedge clk);
    rst_n = 1;
    step();                             // R1: first cycle after release
    en_reset = 1; en_addr = 1; en_cfg = 1; en_susp = 1;

    phase = "R3";  set_addr_evt = 1; step();            // ignored in Powered
    phase = "R2";  bus_reset_evt = 1; step();           // -> Default, chg
    phase = "R8";  reg_wr = 1; reg_sel = 0; reg_wdata = 1; step();  // write 1 inert
    clr_flag(0);
    phase = "R3";  set_addr_evt = 1; step();            // -> Address
    set_addr_evt = 1; step();                           // ignored in Address
    phase = "R4";  set_cfg_evt = 1; cfg_value = 0; step();   // ignored
    set_cfg_evt = 1; cfg_value = 8'd5; step();          // -> Configured
    set_cfg_evt = 1; cfg_value = 8'd7; step();          // ignored
    set_cfg_evt = 1; cfg_value = 0; step();             // -> Address
    set_cfg_evt = 1; cfg_value = 8'd3; step();          // -> Configured
    phase = "R5";  suspend_evt = 1; set_cfg_evt = 1; cfg_value = 0; step(); // -> 111
    suspend_evt = 1; step();                            // ignored
    phase = "R6";  set_addr_evt = 1; set_cfg_evt = 1; cfg_value = 0; step();
    resume_evt = 1; step();                             // -> 011, resm
    resume_evt = 1; step();                             // ignored
    clr_flag(1);
    phase = "R7";  en_reset = 0; en_addr = 0; en_cfg = 0; en_susp = 0;
    clr_flag(0);
    bus_reset_evt = 1; step();
    set_addr_evt = 1; step();
    set_cfg_evt = 1; cfg_value = 8'd1; step();
    suspend_evt = 1; step();
    resume_evt = 1; step();
    en_susp = 1; suspend_evt = 1; step();              // chg set
    phase = "R8";  resume_evt = 1; reg_wr = 1; reg_sel = 1; reg_wdata = 0; step(); // set wins
    reg_wr = 1; reg_sel = 3; reg_wdata = 0; step();     // unused select
    phase = "R2";  suspend_evt = 1; step();
    bus_reset_evt = 1; resume_evt = 1; step();          // suspended -> Default
    bus_reset_evt = 1; suspend_evt = 1; set_addr_evt = 1; step();
    phase = "R10"; ep0_wr = 1; ep0_pid_wdata = 2'd2; ep0_ccpl_wdata = 1; step();
    phase = "R9";  setup_evt = 1; step();
    phase = "R10"; ep0_wr = 1; ep0_pid_wdata = 2'd1; ep0_ccpl_wdata = 0; step(); // ignored
    phase = "R9";  setup_evt = 1; reg_wr = 1; reg_sel = 2; reg_wdata = 0; step(); // set wins
    clr_flag(2);
    phase = "R10"; ep0_wr = 1; ep0_pid_wdata = 2'd3; ep0_ccpl_wdata = 0; step();

    phase = "R2 R4 R5 R6 R7 R8 R9 R10 random";
    for (int i = 0; i < 4000; i++) begin
      bus_reset_evt = ($urandom_range(0, 29) == 0);
      set_addr_evt  = ($urandom_range(0, 3) == 0);
      set_cfg_evt   = ($urandom_range(0, 3) == 0);
      cfg_value     = ($urandom_range(0, 1) == 0) ? '0 : CFG_W'($urandom);
      suspend_evt   = ($urandom_range(0, 9) == 0);
      resume_evt    = ($urandom_range(0, 4) == 0);
      setup_evt     = ($urandom_range(0, 9) == 0);
      en_reset = 1'($urandom); en_addr = 1'($urandom);
      en_cfg   = 1'($urandom); en_susp = 1'($urandom);
      reg_wr   = ($urandom_range(0, 2) == 0);
      reg_sel  = 2'($urandom); reg_wdata = 1'($urandom);
      ep0_wr   = ($urandom_range(0, 2) == 0);
      ep0_pid_wdata = PID_W'($urandom); ep0_ccpl_wdata = 1'($urandom);
      step();
    end
    step();
    finish_run();
  end
endmodule